// File: doc/BRIEF.md
# Edge-Selectable Pulse Event Counter

This block counts transitions on one pin of an 8-bit input port, the event pin. Software controls it through a small synchronous register bus. A control register holds the enable bit, the mode bit, the edge polarity, the pin direction and the overflow interrupt enable. An 8-bit count register can be read or loaded. A flag register holds the overflow status, and software clears that status by writing 1 to it.

The port is sampled on every clock. A count is made when the event pin differs from the value sampled on the previous clock and the new level matches the selected polarity. The pin must also be an input, and the counter must be enabled in event mode. When an increment takes the count from 255 to 0, the overflow flag is set. The flag, gated by its enable, drives the interrupt output.

Top module: `pulse_evt_counter`

## Requirements
- R1: After reset the control register, the count register and the overflow flag read 0, and irq_o is low.
- R2: Control register at address 0, fields: bit 0 enable, bit 1 mode (1 = gated timing, which does not count), bit 2 edge select, bit 3 pin direction (1 = output), bit 4 overflow interrupt enable. The register reads back what was written in bits 4..0, and bits 7..5 read 0.
- R3: Counting happens only when enable is 1 and mode is 0. With any other combination, pin changes leave the count unchanged.
- R4: With edge select 1, a change of the event pin that leaves it high adds one. With edge select 0, a change that leaves it low adds one. A change to the opposite level has no effect.
- R5: A change is detected against the previous clock's sample. A level that stays constant produces no further counts.
- R6: When the direction bit is 1, changes on the event pin are ignored.
- R7: The count register at address 1 is 8 bits wide and wraps from 255 to 0.
- R8: The overflow flag (bit 0 of address 2) is set only when an increment yields 0. Loading 0 through the bus does not set it.
- R9: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R10: irq_o is high exactly when the overflow flag and the interrupt enable are both 1.
- R11: A bus write to the count register takes priority over an increment in the same cycle.
- R12: Read data is registered: rdata_o shows the addressed register one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_i | input | 8 | Input port; bit 7 is the event pin |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is an increment wrapping to zero in the same cycle as a write-1 clear of the flag, or in the same cycle as a bus load of the count. The bench first loads the count to 255. It then toggles the pin so that the qualifying edge lands in the same clock as the bus write. Reading back afterwards shows which action took effect. The count is also preloaded at 255 before each overflow test, so the wrap can be reached without 256 real edges.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam int unsigned EVT_BIT = 7;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_CNT  = 2'd1;
  localparam logic [AW-1:0] ADDR_FLAG = 2'd2;

  typedef struct packed {
    logic ovf_ie;
    logic dir_out;
    logic edge_hi;
    logic gated;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pec_edge_det.sv
module pec_edge_det #(
  parameter int unsigned DW  = 8,
  parameter int unsigned BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] port_i,
  input  logic          dir_out_i,
  input  logic          edge_hi_i,
  output logic          evt_o
);
  logic prev_q;
  logic cur;

  assign cur = port_i[BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  // edge polarity applied to new level
  assign evt_o = !dir_out_i && (cur != prev_q) && (cur == edge_hi_i);

  AST_NO_EVT_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_out_i |-> !evt_o); // R6
endmodule

// File: rtl/pec_counter.sv
module pec_counter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] nxt;

  assign nxt    = cnt_q + 1'b1;
  assign wrap_o = inc_i && !load_i && (nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i)); // R11
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/pec_regs.sv
module pec_regs
  import pec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          wrap_i,
  output ctrl_t         ctrl_o,
  output logic          cnt_load_o,
  output logic          ovf_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned CW = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  ovf_q;
  logic  clr;
  logic [DW-1:0] rmux;

  assign clr        = we_i && addr_i == ADDR_FLAG && wdata_i[0];
  assign cnt_load_o = we_i && addr_i == ADDR_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[CW-1:0]);
  end

  // set wins over same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_q <= 1'b0;
    else if (wrap_i) ovf_q <= 1'b1;
    else if (clr)    ovf_q <= 1'b0;
  end

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      ADDR_CTRL: rmux[CW-1:0] = ctrl_q;
      ADDR_CNT:  rmux = cnt_i;
      ADDR_FLAG: rmux[0] = ovf_q;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rmux;
  end

  assign ctrl_o = ctrl_q;
  assign ovf_o  = ovf_q;

  AST_OVF_SET_ONLY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(wrap_i)); // R8
  AST_OVF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !wrap_i) |=> !ovf_q); // R9
endmodule

// File: rtl/pulse_evt_counter.sv
module pulse_evt_counter
  import pec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    port_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          evt, inc, load, wrap, ovf;
  logic [DW-1:0] cnt;

  pec_edge_det #(.DW(DW), .BIT(EVT_BIT)) u_edge (
    .clk_i, .rst_ni, .port_i,
    .dir_out_i(ctrl.dir_out), .edge_hi_i(ctrl.edge_hi), .evt_o(evt)
  );

  assign inc = evt && ctrl.en && !ctrl.gated;

  pec_counter #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .inc_i(inc), .load_i(load), .load_val_i(wdata_i),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  pec_regs u_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .wrap_i(wrap), .ctrl_o(ctrl), .cnt_load_o(load),
    .ovf_o(ovf), .rdata_o
  );

  assign irq_o = ovf && ctrl.ovf_ie;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf); // R10
  AST_NO_COUNT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && (!ctrl.en || ctrl.gated)) |=> $stable(cnt)); // R3
endmodule

// File: tb/pulse_evt_counter_tb.sv
module pulse_evt_counter_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [7:0] port = 0, wdata = 0;
  logic we = 0, re = 0;
  logic [1:0] addr = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_evt_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic pin(logic v);
    @(negedge clk); port[7] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 cnt", d, 0);
    rd(2, d); chk("R1 flag", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(0, 8'hFF); rd(0, d); chk("R2 ctrl rb", d, 8'h1F);
    wr(0, 8'h00);
  endtask

  task automatic t_qual;
    logic [7:0] d;
    wr(1, 0); port[7] = 0;
    wr(0, 8'h04); pin(1); pin(0); rd(1, d); chk("R3 disabled", d, 0);
    wr(0, 8'h07); pin(1); pin(0); rd(1, d); chk("R3 gated", d, 0);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    wr(1, 0); wr(0, 8'h05);
    pin(1); pin(0); pin(1); rd(1, d); chk("R4 rising", d, 2);
    repeat (5) @(negedge clk); rd(1, d); chk("R5 steady", d, 2);
    wr(1, 0); wr(0, 8'h01);
    pin(0); pin(1); rd(1, d); chk("R4 falling", d, 1);
    wr(0, 8'h09); pin(0); pin(1); rd(1, d); chk("R6 dir out", d, 1);
  endtask

  task automatic t_ovf;
    logic [7:0] d;
    port[7] = 0; wr(0, 8'h15); wr(1, 8'hFF);
    pin(1); rd(1, d); chk("R7 wrap", d, 0);
    rd(2, d); chk("R8 flag set", d, 1);
    chk("R10 irq", irq, 1);
    wr(0, 8'h05); chk("R10 irq masked", irq, 0);
    wr(2, 0); rd(2, d); chk("R9 wr0 keeps", d, 1);
    wr(2, 1); rd(2, d); chk("R9 clear", d, 0);
    wr(1, 0); rd(2, d); chk("R8 load zero no flag", d, 0);
    // set wins over clear, same cycle
    port[7] = 0; wr(1, 8'hFF); pin(0);
    @(negedge clk); port[7] = 1; we = 1; addr = 2; wdata = 1;
    @(negedge clk); we = 0;
    rd(2, d); chk("R9 set wins", d, 1);
    wr(2, 1);
  endtask

  task automatic t_load_prio;
    logic [7:0] d;
    port[7] = 0; wr(0, 8'h05); pin(0);
    @(negedge clk); port[7] = 1; we = 1; addr = 1; wdata = 8'h40;
    @(negedge clk); we = 0;
    rd(1, d); chk("R11 load wins", d, 8'h40);
  endtask

  task automatic t_rdlat;
    wr(1, 8'h33);
    @(negedge clk); re = 1; addr = 1;
    @(posedge clk); #1; chk("R12 latency", rdata, 8'h33);
    @(negedge clk); re = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ctrl; t_qual; t_edges; t_ovf; t_load_prio; t_rdlat;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule